// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 12-bit successive-approximation converter that has a three-wire serial link: an active-low chip select, a serial clock and one data return line. On a start request it lowers chip select and waits a fixed number of system cycles so the converter sees a setup margin. It then runs the serial clock from the system clock through a programmable divider and samples the return line on every rising serial clock edge.

The converter spends the first two serial clocks acquiring its input. After that it sends a mandatory low null bit, then the twelve result bits with the most significant first. When the verify option is chosen for a conversion, the controller keeps clocking and captures the bit-reversed repeat that the converter sends next (B1 up to B11). It checks each repeated bit against the word it already holds. At the end it releases chip select and pulses a done strobe together with the result, a framing flag and a mismatch flag.

The divider setting and the verify choice are taken when a conversion starts. The integrator chooses the divider so that one whole frame, clocks included, repeats at 200 kHz or less.

Top module: `adc_serial_reader`

## Requirements
- R1: Out of reset, and whenever no conversion is running, `cs_n` is high, `sclk` is low, and `busy` and `done` are low.
- R2: A `start` seen while idle drives `cs_n` low and `busy` high on the next cycle. A `start` seen while busy is ignored.
- R3: The first rising `sclk` edge comes `SETUP_CYC` plus D system cycles after `cs_n` falls. After that, each high phase and each low phase of `sclk` lasts D cycles, where D is the latched divider value and 0 is treated as 1.
- R4: `sdo` is sampled only at rising `sclk` edges. The first two rising edges are ignored, and the third is the null bit. If the null bit reads 1, `frame_err` is set for that conversion.
- R5: Rising edges 4 to 15 capture the result, most significant bit first. `result` bit 11 is the first of these bits and bit 0 is the last.
- R6: With verify off, exactly 15 rising edges are issued. `cs_n` rises on the falling `sclk` edge that follows the last rising edge. In that same cycle `busy` falls and `done` is high for exactly one cycle, while `result` and the flags hold until the next start.
- R7: With verify on, exactly 26 rising edges are issued. Edges 16 to 26 carry B1 to B11 in that order, each compared with the matching bit of `result`. Any difference sets `mismatch`.
- R8: `div_in` and `verify_in` are latched at start. Changing them during a conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion (taken when idle) |
| div_in | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| verify_in | input | 1 | Capture and compare the reversed repeat |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | High from start until chip select is released |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 12 | Converted word, most significant bit at bit 11 |
| frame_err | output | 1 | Null bit read high |
| mismatch | output | 1 | Reversed repeat disagreed with the word |

## Verification
A wrong edge counter shows up at once at the ports. The number of rising `sclk` edges seen while `cs_n` is low, and the total number of cycles `cs_n` stays low, both differ from the values computed from the divider and the mode in the same frame. A wrong phase counter shows up in the offset of the first rising edge, or in the number of cycles `sclk` spends high. A shift or compare fault shows up at the next `done` pulse as a wrong `result` word or a flag in the wrong state. Faults injected into the null bit and into single repeat positions confirm that each flag is raised by the bit it covers and by nothing else.

// File: rtl/adc_serial_reader_pkg.sv
package adc_serial_reader_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } rd_state_e;

  localparam int unsigned WORD_BITS      = 12;
  localparam int unsigned NULL_IDX       = 2;
  localparam int unsigned FIRST_DATA_IDX = NULL_IDX + 1;
  localparam int unsigned LAST_DATA_IDX  = FIRST_DATA_IDX + WORD_BITS - 1;
  localparam int unsigned REPEAT_BITS    = WORD_BITS - 1;
  localparam int unsigned EDGES_PLAIN    = LAST_DATA_IDX + 1;
  localparam int unsigned EDGES_VERIFY   = EDGES_PLAIN + REPEAT_BITS;
  localparam int unsigned EDGE_W         = $clog2(EDGES_VERIFY + 1);

endpackage

// File: rtl/adc_serial_reader_tick.sv
module adc_serial_reader_tick #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim_m1,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q >= lim_m1);

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_serial_reader_ctl.sv
module adc_serial_reader_ctl
  import adc_serial_reader_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              verify_in,
  input  logic              tick,
  output logic [DIV_W-1:0]  lim_m1,
  output logic              cnt_clr,
  output logic              clr_data,
  output logic              smp_en,
  output logic [EDGE_W-1:0] edge_idx,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              done
);

  localparam logic [EDGE_W-1:0] LAST_PLAIN  = EDGE_W'(EDGES_PLAIN);
  localparam logic [EDGE_W-1:0] LAST_VERIFY = EDGE_W'(EDGES_VERIFY);
  localparam logic [DIV_W-1:0]  SETUP_M1    = DIV_W'(SETUP_CYC - 1);

  rd_state_e         state_q, state_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              ver_q, ver_d;
  logic              done_q, done_d;
  logic [EDGE_W-1:0] last_edge;

  assign last_edge = ver_q ? LAST_VERIFY : LAST_PLAIN;

  always_comb begin
    state_d  = state_q;
    sclk_d   = sclk_q;
    edge_d   = edge_q;
    div_d    = div_q;
    ver_d    = ver_q;
    done_d   = 1'b0;
    smp_en   = 1'b0;
    cnt_clr  = 1'b0;
    clr_data = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (start) begin
          state_d  = ST_SETUP;
          div_d    = (div_in == '0) ? DIV_W'(1) : div_in;
          ver_d    = verify_in;
          edge_d   = '0;
          sclk_d   = 1'b0;
          clr_data = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tick) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            smp_en = 1'b1;
            edge_d = edge_q + 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (edge_q == last_edge) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      edge_q  <= '0;
      div_q   <= DIV_W'(1);
      ver_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      edge_q  <= edge_d;
      div_q   <= div_d;
      ver_q   <= ver_d;
      done_q  <= done_d;
    end
  end

  assign lim_m1   = (state_q == ST_SETUP) ? SETUP_M1 : (div_q - 1'b1);
  assign edge_idx = edge_q;
  assign cs_n     = (state_q == ST_IDLE);
  assign busy     = (state_q != ST_IDLE);
  assign sclk     = sclk_q;
  assign done     = done_q;

endmodule

// File: rtl/adc_serial_reader_rx.sv
module adc_serial_reader_rx
  import adc_serial_reader_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 smp_en,
  input  logic [EDGE_W-1:0]    idx,
  input  logic                 sdo,
  output logic [WORD_BITS-1:0] word,
  output logic                 frame_err,
  output logic                 mismatch
);

  localparam logic [EDGE_W-1:0] NULL_I  = EDGE_W'(NULL_IDX);
  localparam logic [EDGE_W-1:0] DATA_LO = EDGE_W'(FIRST_DATA_IDX);
  localparam logic [EDGE_W-1:0] DATA_HI = EDGE_W'(LAST_DATA_IDX);
  localparam logic [EDGE_W-1:0] REP_HI  = EDGE_W'(EDGES_VERIFY - 1);

  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 ferr_q, ferr_d;
  logic                 mis_q, mis_d;
  logic [EDGE_W-1:0]    rel;
  logic                 exp_bit;

  assign rel = idx - DATA_HI;

  always_comb begin
    exp_bit = 1'b0;
    for (int i = 0; i < WORD_BITS; i++) begin
      if (rel == EDGE_W'(i)) exp_bit = word_q[i];
    end
  end

  always_comb begin
    word_d = word_q;
    ferr_d = ferr_q;
    mis_d  = mis_q;
    if (clr) begin
      word_d = '0;
      ferr_d = 1'b0;
      mis_d  = 1'b0;
    end else if (smp_en) begin
      if (idx == NULL_I) begin
        ferr_d = sdo;
      end else if (idx >= DATA_LO && idx <= DATA_HI) begin
        word_d = {word_q[WORD_BITS-2:0], sdo};
      end else if (idx > DATA_HI && idx <= REP_HI) begin
        if (sdo != exp_bit) mis_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ferr_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      ferr_q <= ferr_d;
      mis_q  <= mis_d;
    end
  end

  assign word      = word_q;
  assign frame_err = ferr_q;
  assign mismatch  = mis_q;

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_serial_reader_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DIV_W-1:0]     div_in,
  input  logic                 verify_in,
  input  logic                 sdo,
  output logic                 cs_n,
  output logic                 sclk,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_BITS-1:0] result,
  output logic                 frame_err,
  output logic                 mismatch
);

  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  logic              tick;
  logic [DIV_W-1:0]  lim_m1;
  logic              cnt_clr;
  logic              clr_data;
  logic              smp_en;
  logic [EDGE_W-1:0] edge_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  adc_serial_reader_tick #(.CNT_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .clr    (cnt_clr),
    .lim_m1 (lim_m1),
    .tick   (tick)
  );

  adc_serial_reader_ctl #(.DIV_W(DIV_W), .SETUP_CYC(SETUP_CYC)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (start),
    .div_in    (div_in),
    .verify_in (verify_in),
    .tick      (tick),
    .lim_m1    (lim_m1),
    .cnt_clr   (cnt_clr),
    .clr_data  (clr_data),
    .smp_en    (smp_en),
    .edge_idx  (edge_idx),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .busy      (busy),
    .done      (done)
  );

  adc_serial_reader_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clr       (clr_data),
    .smp_en    (smp_en),
    .idx       (edge_idx),
    .sdo       (sdo),
    .word      (result),
    .frame_err (frame_err),
    .mismatch  (mismatch)
  );

endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk (
  input logic clk,
  input logic rst_ok,
  input logic start,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic frame_err,
  input logic mismatch
);

  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !busy |-> cs_n);

  assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && !busy) |=> (!cs_n && busy && !sclk));

  assert_sclk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    cs_n |-> !sclk);

  assert_flags_cleared_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (start && !busy) |=> (!frame_err && !mismatch));

  assert_done_at_release_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(busy) |-> done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    done |-> (!busy && cs_n));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

endmodule

bind adc_serial_reader adc_serial_reader_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .start     (start),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .busy      (busy),
  .done      (done),
  .frame_err (frame_err),
  .mismatch  (mismatch)
);

// File: tb/test_adc_serial_reader.sv
module test_adc_serial_reader;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int SETUP_CYC  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [DIV_W-1:0] div_in = '0;
  logic             verify_in = 1'b0;
  logic             sdo = 1'b1;
  logic             cs_n, sclk, busy, done, frame_err, mismatch;
  logic [11:0]      result;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  logic [11:0] adc_val = '0;
  logic        bad_null = 1'b0;
  int          bad_pos = 0;
  int          fall_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_reader #(.DIV_W(DIV_W), .SETUP_CYC(SETUP_CYC)) i_adc_serial_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .div_in(div_in),
    .verify_in(verify_in), .sdo(sdo), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .done(done), .result(result),
    .frame_err(frame_err), .mismatch(mismatch)
  );

  // Converter model: output changes on falling sclk; 1 stands for high impedance.
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      fall_cnt = 0;
      sdo = 1'b1;
    end else begin
      fall_cnt = fall_cnt + 1;
      if (fall_cnt < 2)       sdo = 1'b1;
      else if (fall_cnt == 2) sdo = bad_null;
      else if (fall_cnt <= 14) sdo = adc_val[14 - fall_cnt];
      else if (fall_cnt <= 25) sdo = adc_val[fall_cnt - 14] ^ (bad_pos == fall_cnt - 14);
      else                    sdo = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_conv(input logic [11:0] val, input int div, input bit ver,
                          input bit nul, input int pos);
    int d, n, low, hi, rises, first, it;
    logic prev_sclk;
    d = (div == 0) ? 1 : div;
    n = ver ? 26 : 15;
    adc_val = val; bad_null = nul; bad_pos = pos;
    @(negedge clk);
    div_in = DIV_W'(div); verify_in = ver; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 cs_n low after start", cs_n, 0);
    check("R2 busy after start", busy, 1);
    low = 0; hi = 0; rises = 0; first = -1; prev_sclk = 1'b0; it = 0;
    while (!done && it < 2000) begin
      if (!cs_n) low++;
      if (sclk) hi++;
      if (sclk && !prev_sclk) begin
        rises++;
        if (first < 0) first = low - 1;
      end
      prev_sclk = sclk;
      // R8 / R2: disturb inputs mid-conversion
      if (it == 5) begin
        div_in = DIV_W'(d + 2); verify_in = ~ver; start = 1'b1;
      end else if (it == 6) begin
        start = 1'b0;
      end
      it++;
      @(negedge clk);
    end
    check("R6 done reached", done, 1);
    check("R6 busy low with done", busy, 0);
    check("R6 cs_n high with done", cs_n, 1);
    check(ver ? "R7 rising edge count" : "R6 rising edge count", rises, n);
    check("R3 first rise offset", first, SETUP_CYC + d);
    check("R3 sclk high cycles", hi, d * n);
    check("R8 cs_n low cycles", low, SETUP_CYC + 2 * d * n);
    check("R5 result word", result, val);
    check("R4 frame_err", frame_err, nul);
    check("R7 mismatch", mismatch, (ver && pos != 0) ? 1 : 0);
    @(negedge clk);
    check("R6 done one cycle", done, 0);
    check("R2 no restart", busy, 0);
    check("R5 result held", result, val);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", cs_n, 1);
    check("R1 sclk in reset", sclk, 0);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 cs_n idle", cs_n, 1);
    check("R1 busy idle", busy, 0);

    for (int div = 1; div <= 3; div++) begin
      for (int ver = 0; ver < 2; ver++) begin
        for (int b = 0; b < 12; b++) begin
          run_conv(12'(1 << b), div, ver[0], 1'b0, 0);
          run_conv(~12'(1 << b), div, ver[0], 1'b0, 0);
        end
        run_conv(12'h000, div, ver[0], 1'b0, 0);
        run_conv(12'hFFF, div, ver[0], 1'b0, 0);
        run_conv(12'hAAA, div, ver[0], 1'b0, 0);
        run_conv(12'h555, div, ver[0], 1'b0, 0);
      end
    end
    // R3: divider 0 behaves as 1
    run_conv(12'h3C7, 0, 1'b0, 1'b0, 0);
    run_conv(12'h3C7, 0, 1'b1, 1'b0, 0);
    // R4: high null bit raises frame_err, result intact
    run_conv(12'h9E1, 2, 1'b0, 1'b1, 0);
    run_conv(12'h9E1, 1, 1'b1, 1'b1, 0);
    // R7: a single corrupted repeat bit at each position
    for (int p = 1; p <= 11; p++) begin
      run_conv(12'hB4D, 1, 1'b1, 1'b0, p);
    end
    // R7: repeat corruption is not seen without verify
    run_conv(12'hB4D, 1, 1'b0, 1'b0, 6);
    // R4: flags clear on the next clean conversion
    run_conv(12'h123, 1, 1'b1, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule